// File: doc/BRIEF.md
# Shared-Datapath Channel Arbiter with Unit Reservation

This block decides which of four virtual channels may use a single shared control and datapath unit in a given cycle. Each channel raises a request line and names the execution unit its current job needs. The arbiter issues at most one grant per cycle. A channel is passed over while its unit is held by a different channel.

Granting a channel reserves its execution unit for that channel. The reservation lasts until the owning channel pulses its release line. A mode input selects plain round-robin or weighted priority. In weighted mode, a 4-bit weight per channel sets how many back-to-back grants the channel at the priority pointer may take before the pointer moves on. Because each channel keeps its own queue and state, arbitration is done per channel and not per request.

Top module: `chan_eu_arbiter`

## Requirements
- R1: After reset, grant_o is all zeros, no unit is reserved, every owner field is zero, the priority pointer is at channel 0 and the weight count is zero.
- R2: Inputs are sampled at a rising edge and the grant appears one cycle later. grant_o has at most one bit set, and a bit is set only for a channel whose req_i was high in the sampled cycle.
- R3: A requesting channel is eligible when its unit is free or already reserved by itself. A channel whose unit (eu_sel_i bits [2c+1:2c] for channel c) is reserved by another channel is not granted.
- R4: With mode_i = 0 (round-robin), eligible channels are searched upward from the pointer, wrapping from 3 to 0, and the first one found is granted. After the grant the pointer moves to the channel after the one granted, and the count is cleared.
- R5: With mode_i = 1 (weighted), the channel at the pointer may take W consecutive grants before the pointer advances past it. W is its weight in weight_i bits [4c+3:4c], and a weight of 0 acts as 1. The count is cleared when the pointer advances.
- R6: In weighted mode, skipped channels use up no weight. When the granted channel is not the one at the pointer, the pointer moves to it and its count starts fresh with this grant.
- R7: When no channel is eligible, grant_o is all zeros and the pointer and count keep their values.
- R8: In the cycle its grant is visible, the granted channel's unit shows rsv_valid_o set and its rsv_owner_o field (bits [2u+1:2u] for unit u) equal to the channel number.
- R9: A release_i pulse from a channel clears, at the next edge, every unit that channel owns, and resets each cleared owner field to 0. Eligibility in that same cycle still uses the reservations as they were before the release. A grant at the same edge is applied after the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 = round-robin, 1 = weighted |
| weight_i | input | 16 | Per-channel weight, 4 bits per channel |
| req_i | input | 4 | Per-channel request |
| eu_sel_i | input | 8 | Per-channel required unit index, 2 bits per channel |
| release_i | input | 4 | Per-channel release pulse |
| grant_o | output | 4 | One-hot grant, or zero |
| rsv_valid_o | output | 4 | Per-unit reservation held |
| rsv_owner_o | output | 8 | Per-unit owning channel, 2 bits per unit |

## Verification
The grant and the reservation changes from a set of inputs are both due exactly one rising edge after those inputs are sampled. This holds for releases as well. The bench drives inputs at the falling edge and steps its behavioural model once with those same inputs. It then compares every output at the following falling edge, so each comparison sees the result of exactly one edge. Before each step, the model also keeps the previous requests and the mask of channels blocked by another owner. The single-grant check and the no-steal check use these saved values from that same step.

// File: rtl/cea_pkg.sv
package cea_pkg;
  typedef enum logic {
    ARB_RR       = 1'b0,
    ARB_WEIGHTED = 1'b1
  } arb_mode_e;
endpackage

// File: rtl/cea_elig.sv
module cea_elig #(
  parameter int NUM_CH = 4,
  parameter int NUM_EU = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int EU_W = (NUM_EU > 1) ? $clog2(NUM_EU) : 1
) (
  input  logic [NUM_CH-1:0]      req_i,
  input  logic [NUM_CH*EU_W-1:0] eu_sel_i,
  input  logic [NUM_EU-1:0]      rsv_valid_i,
  input  logic [NUM_EU*CH_W-1:0] rsv_owner_i,
  output logic [NUM_CH-1:0]      elig_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [EU_W-1:0] unit;
    logic            held_other;
    assign unit       = eu_sel_i[c*EU_W +: EU_W];
    assign held_other = rsv_valid_i[unit] &&
                        (rsv_owner_i[unit*CH_W +: CH_W] != CH_W'(c));
    assign elig_o[c]  = req_i[c] && !held_other;
  end
endmodule

// File: rtl/cea_pick.sv
module cea_pick #(
  parameter int NUM_CH = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0] elig_i,
  input  logic [CH_W-1:0]   ptr_i,
  output logic              found_o,
  output logic [CH_W-1:0]   win_o
);
  // scan from the highest offset down so the lowest offset wins
  always_comb begin
    found_o = 1'b0;
    win_o   = '0;
    for (int k = NUM_CH - 1; k >= 0; k--) begin
      int idx;
      idx = int'(ptr_i) + k;
      if (idx >= NUM_CH) idx = idx - NUM_CH;
      if (elig_i[idx]) begin
        found_o = 1'b1;
        win_o   = CH_W'(idx);
      end
    end
  end
endmodule

// File: rtl/cea_wctl.sv
module cea_wctl
  import cea_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int WT_W   = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   mode_i,
  input  logic [NUM_CH*WT_W-1:0] weight_i,
  input  logic                   fire_i,
  input  logic [CH_W-1:0]        win_i,
  output logic [CH_W-1:0]        ptr_o,
  output logic [WT_W-1:0]        cnt_o
);
  localparam logic [WT_W:0] ONE = (WT_W+1)'(1);

  logic [CH_W-1:0] ptr_q, ptr_d, win_nxt;
  logic [WT_W-1:0] cnt_q, cnt_d;
  logic [WT_W:0]   used, lim, used_inc;

  assign win_nxt  = (win_i == CH_W'(NUM_CH - 1)) ? '0 : win_i + 1'b1;
  assign used_inc = used + ONE;

  always_comb begin
    used  = '0;
    lim   = ONE;
    ptr_d = ptr_q;
    cnt_d = cnt_q;
    if (fire_i) begin
      used = (win_i == ptr_q) ? {1'b0, cnt_q} : '0;
      lim  = {1'b0, weight_i[win_i*WT_W +: WT_W]};
      if (lim == '0) lim = ONE;
      if (arb_mode_e'(mode_i) == ARB_RR || used_inc >= lim) begin
        ptr_d = win_nxt;
        cnt_d = '0;
      end else begin
        ptr_d = win_i;
        cnt_d = used_inc[WT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else begin
      ptr_q <= ptr_d;
      cnt_q <= cnt_d;
    end
  end

  assign ptr_o = ptr_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/cea_rsv.sv
module cea_rsv #(
  parameter int NUM_CH = 4,
  parameter int NUM_EU = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int EU_W = (NUM_EU > 1) ? $clog2(NUM_EU) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_CH-1:0]      release_i,
  input  logic                   fire_i,
  input  logic [CH_W-1:0]        win_i,
  input  logic [EU_W-1:0]        unit_i,
  output logic [NUM_EU-1:0]      valid_o,
  output logic [NUM_EU*CH_W-1:0] owner_o
);
  logic [NUM_EU-1:0] v_q, v_d;
  logic [CH_W-1:0]   own_q [NUM_EU];
  logic [CH_W-1:0]   own_d [NUM_EU];

  // release first, then the new grant
  always_comb begin
    v_d   = v_q;
    own_d = own_q;
    for (int u = 0; u < NUM_EU; u++) begin
      if (v_q[u] && release_i[own_q[u]]) begin
        v_d[u]   = 1'b0;
        own_d[u] = '0;
      end
    end
    if (fire_i) begin
      v_d[unit_i]   = 1'b1;
      own_d[unit_i] = win_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q <= '0;
      for (int u = 0; u < NUM_EU; u++) own_q[u] <= '0;
    end else begin
      v_q   <= v_d;
      own_q <= own_d;
    end
  end

  assign valid_o = v_q;
  for (genvar u = 0; u < NUM_EU; u++) begin : g_own
    assign owner_o[u*CH_W +: CH_W] = own_q[u];
  end
endmodule

// File: rtl/chan_eu_arbiter.sv
module chan_eu_arbiter #(
  parameter int NUM_CH = 4,
  parameter int NUM_EU = 4,
  parameter int WT_W   = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int EU_W = (NUM_EU > 1) ? $clog2(NUM_EU) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   mode_i,
  input  logic [NUM_CH*WT_W-1:0] weight_i,
  input  logic [NUM_CH-1:0]      req_i,
  input  logic [NUM_CH*EU_W-1:0] eu_sel_i,
  input  logic [NUM_CH-1:0]      release_i,
  output logic [NUM_CH-1:0]      grant_o,
  output logic [NUM_EU-1:0]      rsv_valid_o,
  output logic [NUM_EU*CH_W-1:0] rsv_owner_o
);
  logic [NUM_CH-1:0] elig, grant_q, grant_d;
  logic              fire;
  logic [CH_W-1:0]   win_w, ptr_w;
  logic [WT_W-1:0]   cnt_w;
  logic [EU_W-1:0]   win_unit;

  cea_elig #(.NUM_CH(NUM_CH), .NUM_EU(NUM_EU)) u_elig (
    .req_i       (req_i),
    .eu_sel_i    (eu_sel_i),
    .rsv_valid_i (rsv_valid_o),
    .rsv_owner_i (rsv_owner_o),
    .elig_o      (elig)
  );

  cea_pick #(.NUM_CH(NUM_CH)) u_pick (
    .elig_i  (elig),
    .ptr_i   (ptr_w),
    .found_o (fire),
    .win_o   (win_w)
  );

  cea_wctl #(.NUM_CH(NUM_CH), .WT_W(WT_W)) u_wctl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (mode_i),
    .weight_i (weight_i),
    .fire_i   (fire),
    .win_i    (win_w),
    .ptr_o    (ptr_w),
    .cnt_o    (cnt_w)
  );

  assign win_unit = eu_sel_i[win_w*EU_W +: EU_W];

  cea_rsv #(.NUM_CH(NUM_CH), .NUM_EU(NUM_EU)) u_rsv (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .release_i (release_i),
    .fire_i    (fire),
    .win_i     (win_w),
    .unit_i    (win_unit),
    .valid_o   (rsv_valid_o),
    .owner_o   (rsv_owner_o)
  );

  always_comb begin
    grant_d = '0;
    if (fire) grant_d[win_w] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) grant_q <= '0;
    else         grant_q <= grant_d;
  end

  assign grant_o = grant_q;
endmodule

// File: rtl/chan_eu_arbiter_chk.sv
module chan_eu_arbiter_chk #(
  parameter int NUM_CH = 4,
  parameter int NUM_EU = 4,
  parameter int WT_W   = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int EU_W = (NUM_EU > 1) ? $clog2(NUM_EU) : 1
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [NUM_CH-1:0]      req_i,
  input logic [NUM_CH*EU_W-1:0] eu_sel_i,
  input logic [NUM_CH-1:0]      release_i,
  input logic [NUM_CH-1:0]      grant_o,
  input logic [NUM_EU-1:0]      rsv_valid_o,
  input logic [NUM_EU*CH_W-1:0] rsv_owner_o,
  input logic [CH_W-1:0]        ptr_i,
  input logic [WT_W-1:0]        cnt_i
);
  p_single_grant_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));

  p_grant_had_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o & ~$past(req_i)) == '0);

  p_idle_keeps_ptr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o == '0) |-> (ptr_i == $past(ptr_i) && cnt_i == $past(cnt_i)));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    p_no_steal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grant_o[c] |-> !($past(rsv_valid_o[eu_sel_i[c*EU_W +: EU_W]]) &&
        $past(rsv_owner_o[eu_sel_i[c*EU_W +: EU_W]*CH_W +: CH_W]) != CH_W'(c)));

    p_grant_reserves_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grant_o[c] |-> (rsv_valid_o[$past(eu_sel_i[c*EU_W +: EU_W])] &&
        rsv_owner_o[$past(eu_sel_i[c*EU_W +: EU_W])*CH_W +: CH_W] == CH_W'(c)));

    for (genvar u = 0; u < NUM_EU; u++) begin : g_u
      p_release_frees_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(release_i[c]) && $past(rsv_valid_o[u]) &&
         $past(rsv_owner_o[u*CH_W +: CH_W]) == CH_W'(c) &&
         !(grant_o[c] && $past(eu_sel_i[c*EU_W +: EU_W]) == EU_W'(u)))
        |-> !rsv_valid_o[u]);
    end
  end
endmodule

bind chan_eu_arbiter chan_eu_arbiter_chk #(
  .NUM_CH(NUM_CH), .NUM_EU(NUM_EU), .WT_W(WT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .eu_sel_i    (eu_sel_i),
  .release_i   (release_i),
  .grant_o     (grant_o),
  .rsv_valid_o (rsv_valid_o),
  .rsv_owner_o (rsv_owner_o),
  .ptr_i       (ptr_w),
  .cnt_i       (cnt_w)
);

// File: tb/tb_chan_eu_arbiter.sv
`timescale 1ns/1ps
module tb_chan_eu_arbiter;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mode_i = 1'b0;
  logic [15:0] weight_i = '0;
  logic [3:0]  req_i = '0;
  logic [7:0]  eu_sel_i = '0;
  logic [3:0]  release_i = '0;
  logic [3:0]  grant_o;
  logic [3:0]  rsv_valid_o;
  logic [7:0]  rsv_owner_o;

  always #2.5 clk_i = ~clk_i;

  chan_eu_arbiter dut (.*);

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  // behavioural model state
  int m_ptr, m_cnt;
  int m_valid[4];
  int m_owner[4];
  logic [3:0] m_grant;
  logic [3:0] prev_req, blocked;
  string g_tag;
  bit rel_hit;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int sel(input int c);
    return int'(eu_sel_i[2*c +: 2]);
  endfunction

  task automatic model_step();
    int win, w, used;
    bit el;
    win = -1;
    blocked = '0;
    prev_req = req_i;
    for (int c = 0; c < 4; c++)
      blocked[c] = req_i[c] && m_valid[sel(c)] != 0 && m_owner[sel(c)] != c;
    for (int k = 0; k < 4; k++) begin
      int c;
      c = (m_ptr + k) % 4;
      el = req_i[c] && !blocked[c];
      if (el && win < 0) win = c;
    end
    rel_hit = 1'b0;
    for (int u = 0; u < 4; u++)
      if (m_valid[u] != 0 && release_i[m_owner[u]]) begin
        m_valid[u] = 0; m_owner[u] = 0; rel_hit = 1'b1;
      end
    m_grant = '0;
    if (win < 0) g_tag = "R7";
    else begin
      m_grant[win] = 1'b1;
      m_valid[sel(win)] = 1;
      m_owner[sel(win)] = win;
      if (mode_i == 1'b0) begin
        g_tag = "R4";
        m_ptr = (win + 1) % 4; m_cnt = 0;
      end else begin
        g_tag = (win != m_ptr) ? "R6" : "R5";
        used = (win == m_ptr) ? m_cnt : 0;
        w = int'(weight_i[4*win +: 4]);
        if (w == 0) w = 1;
        if (used + 1 >= w) begin m_ptr = (win + 1) % 4; m_cnt = 0; end
        else begin m_ptr = win; m_cnt = used + 1; end
      end
    end
  endtask

  task automatic compare();
    logic [3:0] ev;
    logic [7:0] eo;
    for (int u = 0; u < 4; u++) begin
      ev[u] = (m_valid[u] != 0);
      eo[2*u +: 2] = 2'(m_owner[u]);
    end
    chk(grant_o == m_grant, g_tag, 32'(grant_o), 32'(m_grant));
    chk({rsv_valid_o, rsv_owner_o} == {ev, eo}, rel_hit ? "R9" : "R8",
        32'({rsv_valid_o, rsv_owner_o}), 32'({ev, eo}));
    chk($countones(grant_o) <= 1 && (grant_o & ~prev_req) == '0, "R2",
        32'(grant_o), 32'(prev_req));
    chk((grant_o & blocked) == '0, "R3", 32'(grant_o), 32'(blocked));
  endtask

  task automatic cyc();
    model_step();
    @(posedge clk_i);
    @(negedge clk_i);
    compare();
  endtask

  initial begin
    m_ptr = 0; m_cnt = 0; m_grant = '0;
    for (int u = 0; u < 4; u++) begin m_valid[u] = 0; m_owner[u] = 0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(grant_o == '0, "R1", 32'(grant_o), 0);
    chk(rsv_valid_o == '0 && rsv_owner_o == '0, "R1",
        32'({rsv_valid_o, rsv_owner_o}), 0);

    // round-robin, distinct units, everyone releases each cycle
    mode_i = 1'b0; req_i = 4'hf; eu_sel_i = 8'b11_10_01_00; release_i = 4'hf;
    repeat (40) cyc();

    // weighted: weights 3,1,0,2 for channels 0..3
    mode_i = 1'b1; weight_i = 16'h2013;
    repeat (40) cyc();

    // idle: pointer and count held
    req_i = '0;
    repeat (8) cyc();
    req_i = 4'hf;
    repeat (12) cyc();

    // all channels need the same unit, no releases: only the first owner runs
    release_i = '0; eu_sel_i = 8'h00; req_i = 4'hf;
    repeat (6) cyc();
    release_i = 4'hf;
    repeat (4) cyc();

    // random traffic with conflicts, sparse releases, mode switching
    for (int i = 0; i < 3000; i++) begin
      if (i % 64 == 0) begin
        mode_i = 1'($urandom_range(0, 1));
        weight_i = 16'($urandom);
      end
      req_i = 4'($urandom);
      eu_sel_i = 8'($urandom);
      release_i = 4'($urandom) & 4'($urandom);
      cyc();
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(100000 * 5);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule